// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block is the event side of a power-management register set. It sits in a 64-byte I/O window, the window being placed by a base register and switched on by an I/O-enable bit. Inside the window the block holds three 16-bit registers and a free-running timer:

- an event-status register whose bits are cleared by writing 1;
- a matching event-enable register;
- a control register.

Status bits are set by event inputs: a power-button press, a real-time-clock alarm, a global-lock release, and a carry out of the top of the timer.

The system control interrupt (SCI) is a level output. It is high while any of those four status bits is set together with its enable bit, or while the selected general-purpose-event (GPE) status bit and its enable bit are both set.

A separate advanced-power-management (APM) command byte turns the ACPI-mode bit of the control register on or off. Each APM write can also raise a system-management interrupt (SMI) pulse when a configuration input allows it.

Top module: `pm_evt_ctrl`

## Requirements
- R1: Inside the window, byte offset 0x00 reads the status register, 0x02 the enable register, 0x04 the control register and 0x08 the timer (count in the low TMR_W bits, upper bits zero). Any other offset reads 0.
- R2: An access falls in the window only when io_en is 1 and io_addr[15:6] equals io_base[15:6] (the base masked with 0xFFC0). Outside the window, reads return 0 and writes change nothing.
- R3: Status bit positions are timer 0, global lock 5, power button 8 and RTC 10; all other status bits read 0. An event input high in a cycle sets its bit. Writing 1 to a bit at offset 0x00 clears it. An event in the same cycle as the clearing write leaves the bit set.
- R4: sci is 1 exactly when (status AND enable) is nonzero in any of bits 0, 5, 8 or 10, or when gpe_sts[GPE_BIT] and gpe_en[GPE_BIT] are both 1 (GPE_BIT defaults to 1). The output follows register state in the cycle after the write or event, and follows the GPE inputs with no clock delay.
- R5: The timer resets to 0, advances by one in every cycle where tick is 1, and wraps from all ones to 0.
- R6: A timer wrap sets status bit 0 only while enable bit 0 is 1 and status bit 0 is 0. A wrap while enable bit 0 is 0 leaves status bit 0 at 0.
- R7: An APM write of 0xF1 sets control bit 0. A write of 0xF0 clears it. Any other value leaves the control register unchanged. An APM write in the same cycle as a control write decides bit 0.
- R8: smi is a one-cycle pulse in the cycle after any APM write made while smi_on_apm is 1, whatever the value written. At all other times it is 0.
- R9: After reset, the status, enable, control and timer registers are 0, and sci and smi are 0 (with the GPE inputs low).
- R10: The enable and control registers store all 16 written bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O decode enable |
| io_base | input | 16 | Window base; bits 5:0 are ignored |
| io_addr | input | 16 | Access address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe (data is combinational) |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data; 0 when not reading a register |
| tick | input | 1 | Timer advance enable |
| pwrbtn | input | 1 | Power-button event |
| rtc_evt | input | 1 | Real-time-clock alarm event |
| glbl_evt | input | 1 | Global-lock release event |
| gpe_sts | input | GPE_W | General-purpose-event status bits |
| gpe_en | input | GPE_W | General-purpose-event enable bits |
| apm_wr | input | 1 | APM command write strobe |
| apm_data | input | 8 | APM command byte |
| smi_on_apm | input | 1 | Allow SMI on APM writes |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System-management interrupt pulse |

## Verification
The bench builds the block with TMR_W = 8, so the timer wraps every 256 ticks. With this width, wraps both with and without the timer enable, and the set-while-armed rule, are reached many times within a short run. GPE_W stays at 4 with GPE_BIT = 1. This lets the bench show that GPE bit 2 (and the others) never reach sci. A long stretch of mixed random stimulus runs through the same per-cycle model, which covers simultaneous events and clears, and APM writes that collide with control writes.

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl #(
  parameter int TMR_W = 24,
  parameter int GPE_W = 4,
  parameter int GPE_BIT = 1,
  parameter logic [7:0] APM_ON = 8'hF1,
  parameter logic [7:0] APM_OFF = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_en,
  input  logic [15:0]      io_base,
  input  logic [15:0]      io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [15:0]      io_wdata,
  output logic [31:0]      io_rdata,
  input  logic             tick,
  input  logic             pwrbtn,
  input  logic             rtc_evt,
  input  logic             glbl_evt,
  input  logic [GPE_W-1:0] gpe_sts,
  input  logic [GPE_W-1:0] gpe_en,
  input  logic             apm_wr,
  input  logic [7:0]       apm_data,
  input  logic             smi_on_apm,
  output logic             sci,
  output logic             smi
);
  localparam logic [15:0] WIN_MASK = 16'hFFC0;
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam logic [15:0] EVT_MASK = 16'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC));
  localparam logic [GPE_W-1:0] GPE_SEL = GPE_W'(1 << GPE_BIT);
  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_CTL = 6'h04;
  localparam logic [5:0] OFS_TMR = 6'h08;

  logic [15:0]      sts_q, en_q, ctl_q, set_v, clr_v;
  logic [TMR_W-1:0] tmr_q;
  logic             smi_q, hit, tmr_set;
  logic [5:0]       off;

  assign hit = io_en && ((io_addr & WIN_MASK) == (io_base & WIN_MASK));
  assign off = io_addr[5:0];

  assign tmr_set = tick && (&tmr_q) && en_q[B_TMR] && !sts_q[B_TMR];

  always_comb begin
    set_v = '0;
    set_v[B_TMR] = tmr_set;
    set_v[B_GBL] = glbl_evt;
    set_v[B_PWR] = pwrbtn;
    set_v[B_RTC] = rtc_evt;
  end

  assign clr_v = (io_wr && hit && off == OFS_STS) ? io_wdata : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      tmr_q <= '0;
      smi_q <= 1'b0;
    end else begin
      sts_q <= ((sts_q & ~clr_v) | set_v) & EVT_MASK;
      tmr_q <= tmr_q + TMR_W'(tick);
      smi_q <= apm_wr && smi_on_apm;
      if (io_wr && hit && off == OFS_EN) en_q <= io_wdata;
      if (io_wr && hit && off == OFS_CTL) ctl_q <= io_wdata;
      if (apm_wr && apm_data == APM_ON) ctl_q[0] <= 1'b1;
      else if (apm_wr && apm_data == APM_OFF) ctl_q[0] <= 1'b0;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) begin
      case (off)
        OFS_STS: io_rdata = {16'h0, sts_q};
        OFS_EN:  io_rdata = {16'h0, en_q};
        OFS_CTL: io_rdata = {16'h0, ctl_q};
        OFS_TMR: io_rdata = 32'(tmr_q);
        default: io_rdata = '0;
      endcase
    end
  end

  assign sci = (|(sts_q & en_q & EVT_MASK)) || (|(gpe_sts & gpe_en & GPE_SEL));
  assign smi = smi_q;
endmodule

module pm_evt_ctrl_chk #(
  parameter logic [7:0] APM_ON = 8'hF1,
  parameter logic [7:0] APM_OFF = 8'hF0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        apm_wr,
  input logic [7:0]  apm_data,
  input logic        smi_on_apm,
  input logic        smi,
  input logic        pwrbtn,
  input logic        io_rd,
  input logic        hit,
  input logic [31:0] io_rdata,
  input logic [15:0] sts,
  input logic        en0,
  input logic        ctl0
);
  assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(apm_wr && smi_on_apm));
  assert_smi_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && smi_on_apm) |=> smi);
  assert_apm_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_data == APM_ON) |=> ctl0);
  assert_apm_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_data == APM_OFF) |=> !ctl0);
  assert_pwrbtn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn |=> sts[8]);
  assert_tmr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !sts[0]) |=> !sts[0]);
  assert_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !hit) |-> io_rdata == 32'h0);
endmodule

bind pm_evt_ctrl pm_evt_ctrl_chk #(.APM_ON(APM_ON), .APM_OFF(APM_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .apm_wr(apm_wr), .apm_data(apm_data),
  .smi_on_apm(smi_on_apm), .smi(smi), .pwrbtn(pwrbtn), .io_rd(io_rd),
  .hit(hit), .io_rdata(io_rdata), .sts(sts_q), .en0(en_q[0]), .ctl0(ctl_q[0])
);

// File: tb/pm_evt_ctrl_test.sv
module pm_evt_ctrl_test;
  localparam int TW = 8;
  localparam logic [15:0] BASE = 16'hAC40;

  logic clk = 0, rst_n = 0;
  logic io_en = 0, io_wr = 0, io_rd = 0, tick = 0, pwrbtn = 0, rtc_evt = 0, glbl_evt = 0;
  logic apm_wr = 0, smi_on_apm = 0;
  logic [15:0] io_base = BASE, io_addr = BASE, io_wdata = 0;
  logic [3:0] gpe_sts = 0, gpe_en = 0;
  logic [7:0] apm_data = 0;
  logic [31:0] io_rdata;
  logic sci, smi;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_sts, m_en, m_ctl;
  int m_tmr;
  logic m_smi;

  always #2 clk = ~clk;

  pm_evt_ctrl #(.TMR_W(TW), .GPE_W(4), .GPE_BIT(1)) uut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_base(io_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tick(tick), .pwrbtn(pwrbtn), .rtc_evt(rtc_evt), .glbl_evt(glbl_evt),
    .gpe_sts(gpe_sts), .gpe_en(gpe_en), .apm_wr(apm_wr), .apm_data(apm_data),
    .smi_on_apm(smi_on_apm), .sci(sci), .smi(smi));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_hit();
    return io_en && (io_addr[15:6] == io_base[15:6]);
  endfunction

  function automatic logic [31:0] m_read();
    if (!io_rd || !m_hit()) return 0;
    case (io_addr[5:0])
      6'h00: return {16'h0, m_sts};
      6'h02: return {16'h0, m_en};
      6'h04: return {16'h0, m_ctl};
      6'h08: return m_tmr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ctl = 0; m_tmr = 0; m_smi = 0;
    end else begin
      logic [15:0] setv, clrv, nsts;
      setv = 0;
      if (tick && m_tmr == (1 << TW) - 1 && m_en[0] && !m_sts[0]) setv[0] = 1;
      if (glbl_evt) setv[5] = 1;
      if (pwrbtn) setv[8] = 1;
      if (rtc_evt) setv[10] = 1;
      clrv = (io_wr && m_hit() && io_addr[5:0] == 6'h00) ? io_wdata : 16'h0;
      nsts = ((m_sts & ~clrv) | setv) & 16'h0521;
      if (io_wr && m_hit() && io_addr[5:0] == 6'h02) m_en = io_wdata;
      if (io_wr && m_hit() && io_addr[5:0] == 6'h04) m_ctl = io_wdata;
      if (apm_wr && apm_data == 8'hF1) m_ctl[0] = 1;
      else if (apm_wr && apm_data == 8'hF0) m_ctl[0] = 0;
      m_tmr = (m_tmr + (tick ? 1 : 0)) % (1 << TW);
      m_smi = apm_wr && smi_on_apm;
      m_sts = nsts;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_sci;
      exp_sci = ((m_sts & m_en & 16'h0521) != 0) || (gpe_sts[1] && gpe_en[1]);
      chk(sci === exp_sci, "R4 sci", {31'h0, sci}, {31'h0, exp_sci});
      chk(smi === m_smi, "R8 smi", {31'h0, smi}, {31'h0, m_smi});
      if (io_rd) chk(io_rdata === m_read(), "R1 rdata", io_rdata, m_read());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] off, input logic [15:0] d);
    io_addr = BASE | 16'(off); io_wdata = d; io_wr = 1;
    step(); io_wr = 0;
  endtask

  task automatic rd(input logic [5:0] off, input logic [31:0] exp, input string req);
    io_addr = BASE | 16'(off); io_rd = 1;
    @(negedge clk); #0.5;
    chk(io_rdata === exp, req, io_rdata, exp);
    step(); io_rd = 0;
  endtask

  task automatic see_sci(input logic exp, input string req);
    @(negedge clk); #0.5;
    chk(sci === exp, req, {31'h0, sci}, {31'h0, exp});
    step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; io_en = 1;
    step();
    // R9 reset state
    chk(sci === 0 && smi === 0, "R9 outputs", {30'h0, sci, smi}, 0);
    rd(6'h00, 0, "R9 status");
    rd(6'h02, 0, "R9 enable");
    rd(6'h04, 0, "R9 control");
    rd(6'h08, 0, "R9 timer");
    // R10 / R1 decode
    wr(6'h02, 16'hFFFF); rd(6'h02, 32'hFFFF, "R10 enable");
    wr(6'h04, 16'h1234); rd(6'h04, 32'h1234, "R10 control");
    rd(6'h06, 0, "R1 hole 06"); rd(6'h0A, 0, "R1 hole 0A"); rd(6'h3E, 0, "R1 hole 3E");
    // R3 events, W1C, bit positions
    pwrbtn = 1; step(); pwrbtn = 0;
    rd(6'h00, 32'h0100, "R3 pwrbtn bit 8");
    see_sci(1, "R4 pwrbtn enabled");
    wr(6'h00, 16'h0100); rd(6'h00, 0, "R3 w1c");
    see_sci(0, "R4 cleared");
    glbl_evt = 1; rtc_evt = 1; step(); glbl_evt = 0; rtc_evt = 0;
    rd(6'h00, 32'h0420, "R3 glbl 5 rtc 10");
    wr(6'h00, 16'hFBDF); rd(6'h00, 32'h0420, "R3 write zero keeps");
    wr(6'h00, 16'hFFFF); rd(6'h00, 0, "R3 clear all");
    pwrbtn = 1; wr(6'h00, 16'h0100); pwrbtn = 0;
    rd(6'h00, 32'h0100, "R3 event beats clear");
    wr(6'h00, 16'hFFFF);
    // R4 masking and GPE
    wr(6'h02, 16'h0000);
    pwrbtn = 1; step(); pwrbtn = 0;
    see_sci(0, "R4 masked pwrbtn");
    wr(6'h02, 16'h0100); see_sci(1, "R4 enable late");
    wr(6'h02, 16'h0000); wr(6'h00, 16'hFFFF);
    gpe_sts = 4'h2; gpe_en = 4'h2; see_sci(1, "R4 gpe bit1");
    gpe_en = 4'h0; see_sci(0, "R4 gpe masked");
    gpe_sts = 4'hD; gpe_en = 4'hD; see_sci(0, "R4 gpe other bits");
    gpe_sts = 0; gpe_en = 0;
    // R2 window
    io_en = 0; wr(6'h02, 16'hFFFF); rd(6'h02, 0, "R2 io_en off read");
    io_en = 1; rd(6'h02, 0, "R2 io_en off write ignored");
    io_addr = BASE + 16'h0042; io_wdata = 16'h0F0F; io_wr = 1; step(); io_wr = 0;
    rd(6'h02, 0, "R2 other window write");
    io_base = BASE | 16'h003F; rd(6'h04, 32'h1234, "R2 base low bits ignored");
    io_base = BASE;
    // R5 timer
    rd(6'h08, m_tmr, "R5 timer hold");
    begin
      int t0;
      t0 = m_tmr;
      tick = 1; step(); step(); step(); tick = 0;
      rd(6'h08, (t0 + 3) % 256, "R5 advance 3");
    end
    // R6 overflow guard
    tick = 1; repeat (300) step(); tick = 0;
    rd(6'h00, 0, "R6 wrap while disabled");
    wr(6'h02, 16'h0001);
    tick = 1; repeat (300) step(); tick = 0;
    rd(6'h00, 32'h0001, "R6 wrap while armed");
    see_sci(1, "R4 timer sci");
    wr(6'h00, 16'h0001); wr(6'h02, 16'h0000);
    // R7 APM
    wr(6'h04, 16'h0000);
    apm_wr = 1; apm_data = 8'hF1; step(); apm_wr = 0;
    rd(6'h04, 32'h0001, "R7 apm on");
    apm_wr = 1; apm_data = 8'h55; step(); apm_wr = 0;
    rd(6'h04, 32'h0001, "R7 apm other");
    apm_wr = 1; apm_data = 8'hF0; step(); apm_wr = 0;
    rd(6'h04, 32'h0000, "R7 apm off");
    // R8 SMI
    smi_on_apm = 0; apm_wr = 1; apm_data = 8'hF1; step(); apm_wr = 0;
    @(negedge clk); #0.5; chk(smi === 0, "R8 no smi", {31'h0, smi}, 0);
    smi_on_apm = 1; step(); apm_wr = 1; apm_data = 8'h12; step(); apm_wr = 0;
    @(negedge clk); #0.5; chk(smi === 1, "R8 smi pulse", {31'h0, smi}, 1);
    step();
    @(negedge clk); #0.5; chk(smi === 0, "R8 smi one cycle", {31'h0, smi}, 0);
    step();
    // mixed stimulus against the model
    for (int i = 0; i < 6000; i++) begin
      logic [5:0] offs [4];
      offs = '{6'h00, 6'h02, 6'h04, 6'h08};
      io_wr = ($urandom % 4) == 0;
      io_rd = !io_wr && ($urandom % 2);
      io_addr = (($urandom % 8) == 0 ? BASE + 16'h0040 : BASE) | 16'(offs[$urandom % 4]);
      io_wdata = 16'($urandom);
      io_en = ($urandom % 10) != 0;
      tick = ($urandom % 4) != 0;
      pwrbtn = ($urandom % 16) == 0;
      rtc_evt = ($urandom % 16) == 0;
      glbl_evt = ($urandom % 16) == 0;
      gpe_sts = 4'($urandom); gpe_en = 4'($urandom);
      apm_wr = ($urandom % 8) == 0;
      apm_data = ($urandom % 3) == 0 ? 8'hF0 : (($urandom % 2) ? 8'hF1 : 8'h3C);
      smi_on_apm = $urandom % 2;
      step();
    end
    io_wr = 0; io_rd = 0; apm_wr = 0; pwrbtn = 0; rtc_evt = 0; glbl_evt = 0; tick = 0;
    step(); step();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule